// File: doc/BRIEF.md
# Tournament Branch Predictor

This block predicts the direction of a conditional branch by running two predictors of different kinds side by side and letting a trained selector pick one of them for each branch. The local side keeps a short outcome history per group of branch addresses and uses that history to index a table of 3-bit saturating counters. The global side uses a shift register of the most recent outcomes across all branches to index a table of 2-bit counters. A table of 2-bit chooser counters, indexed by the branch address, decides per branch which side to follow.

On a fetch, the front end presents the PC and gets back, in the same cycle, the final prediction, both component predictions and the two history values that were used. It keeps those values with the branch. When the branch resolves, it sends back the PC, the real outcome and the saved values. The block then trains both component counters at the saved indices, moves the chooser toward whichever side alone was right, and shifts the outcome into the local and global histories. Histories are updated only at resolve time, so no repair logic is needed.

Top module: `tournament_predictor`

## Requirements
- R1: After reset every history is zero, every 3-bit counter holds 3, every 2-bit global counter holds 1 and every chooser holds 1, so all three predictions read not-taken and the chooser follows the local side.
- R2: The chooser entry is selected by `fetch_pc[PC_LSB +: CHOOSE_IDX_W]`; when its counter is 2 or more `pred_taken` equals `pred_global`, otherwise it equals `pred_local`.
- R3: The local history entry is selected by `fetch_pc[PC_LSB +: LHIST_IDX_W]` and shown on `snap_lhist`; a resolve shifts `res_taken` into bit 0 of the entry selected by `res_pc` and drops its top bit.
- R4: `pred_local` is the top bit of the 3-bit counter indexed by the local history; these counters saturate at 0 and 7.
- R5: `pred_global` is the top bit of the 2-bit counter indexed by the global history; these counters saturate at 0 and 3.
- R6: The global history, shown on `snap_ghist`, shifts `res_taken` into bit 0 on each resolve and drops its top bit.
- R7: On a resolve the chooser at the `res_pc` index steps up by one (toward global, saturating at 3) when only `res_pred_global` matched the outcome, steps down by one (toward local, saturating at 0) when only `res_pred_local` matched, and is unchanged otherwise.
- R8: On every resolve the local counter at `res_lhist` and the global counter at `res_ghist` both step toward `res_taken`, whichever side the chooser picked and whatever the current histories are.
- R9: Lookup outputs follow `fetch_pc` in the same cycle; a resolve's effect is visible from the following cycle.
- R10: While `res_valid` is low the other resolve inputs have no effect on any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fetch_pc | input | PC_W | Address being looked up |
| pred_taken | output | 1 | Final prediction, 1 = taken |
| pred_local | output | 1 | Local-side prediction |
| pred_global | output | 1 | Global-side prediction |
| snap_lhist | output | LHIST_W | Local history used for this lookup |
| snap_ghist | output | GHIST_W | Global history used for this lookup |
| res_valid | input | 1 | A branch resolves this cycle |
| res_pc | input | PC_W | Address of the resolving branch |
| res_taken | input | 1 | Real outcome, 1 = taken |
| res_lhist | input | LHIST_W | Local history saved at lookup |
| res_ghist | input | GHIST_W | Global history saved at lookup |
| res_pred_local | input | 1 | Local prediction saved at lookup |
| res_pred_global | input | 1 | Global prediction saved at lookup |

## Verification
The bench goes after the four right/wrong pairings of the two component predictions, since a design that trained the chooser when both sides agreed, or moved it the wrong way, would drift to the wrong side and flip `pred_taken` on later lookups. It feeds resolves whose saved histories differ from the live ones, so a design that indexed training by the current history instead of the snapshot would leave the wrong counters changed. Long runs of one outcome drive the counters against both limits, where a missing saturation would wrap and invert a prediction. Addresses that share low bits but differ above the index check aliasing, and cycles with garbage on the resolve inputs but `res_valid` low check that nothing moves.

// File: rtl/tp_pkg.sv
package tp_pkg;

    // One training action for a counter table.
    typedef struct packed {
        logic en;
        logic up;
    } tp_train_t;

    // Chooser moves only when exactly one side matched the outcome;
    // "up" means toward the global side.
    function automatic tp_train_t tp_chooser_train(
        input logic valid,
        input logic loc_pred,
        input logic glb_pred,
        input logic outcome
    );
        tp_train_t tr;
        logic loc_ok;
        logic glb_ok;
        loc_ok = (loc_pred == outcome);
        glb_ok = (glb_pred == outcome);
        tr.en  = valid && (loc_ok != glb_ok);
        tr.up  = glb_ok;
        return tr;
    endfunction

endpackage

// File: rtl/tp_sat_table.sv
module tp_sat_table #(
    parameter int IDX_W = 12,
    parameter int CW    = 2,
    parameter int INIT  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CW-1:0]    rd_val,
    input  logic             upd_en,
    input  logic             upd_up,
    input  logic [IDX_W-1:0] upd_idx
);
    localparam int ENTRIES = 1 << IDX_W;
    localparam logic [CW-1:0] INIT_V = CW'(INIT);

    logic [CW-1:0] tbl_q [ENTRIES];
    logic [CW-1:0] tbl_d [ENTRIES];

    function automatic logic [CW-1:0] sat_step(input logic [CW-1:0] v, input logic up);
        if (up) return (v == '1) ? v : v + 1'b1;
        return (v == '0) ? v : v - 1'b1;
    endfunction

    always_comb begin
        tbl_d = tbl_q;
        if (upd_en) tbl_d[upd_idx] = sat_step(tbl_q[upd_idx], upd_up);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tbl_q <= '{default: INIT_V};
        else        tbl_q <= tbl_d;
    end

    assign rd_val = tbl_q[rd_idx];
endmodule

// File: rtl/tp_hist_table.sv
module tp_hist_table #(
    parameter int IDX_W = 10,
    parameter int HW    = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [HW-1:0]    rd_hist,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_bit
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [HW-1:0] tbl_q [ENTRIES];
    logic [HW-1:0] tbl_d [ENTRIES];

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en) tbl_d[wr_idx] = {tbl_q[wr_idx][HW-2:0], wr_bit};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tbl_q <= '{default: '0};
        else        tbl_q <= tbl_d;
    end

    assign rd_hist = tbl_q[rd_idx];
endmodule

// File: rtl/tp_ghr.sv
module tp_ghr #(
    parameter int HW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shift_en,
    input  logic          shift_bit,
    output logic [HW-1:0] hist
);
    logic [HW-1:0] hist_d;
    logic [HW-1:0] hist_q;

    always_comb begin
        hist_d = hist_q;
        if (shift_en) hist_d = {hist_q[HW-2:0], shift_bit};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= hist_d;
    end

    assign hist = hist_q;
endmodule

// File: rtl/tournament_predictor.sv
module tournament_predictor
    import tp_pkg::*;
#(
    parameter int PC_W         = 32,
    parameter int PC_LSB       = 2,
    parameter int CHOOSE_IDX_W = 12,
    parameter int CHOOSE_W     = 2,
    parameter int LHIST_IDX_W  = 10,
    parameter int LHIST_W      = 10,
    parameter int LCTR_W       = 3,
    parameter int GHIST_W      = 12,
    parameter int GCTR_W       = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PC_W-1:0]    fetch_pc,
    output logic               pred_taken,
    output logic               pred_local,
    output logic               pred_global,
    output logic [LHIST_W-1:0] snap_lhist,
    output logic [GHIST_W-1:0] snap_ghist,
    input  logic               res_valid,
    input  logic [PC_W-1:0]    res_pc,
    input  logic               res_taken,
    input  logic [LHIST_W-1:0] res_lhist,
    input  logic [GHIST_W-1:0] res_ghist,
    input  logic               res_pred_local,
    input  logic               res_pred_global
);
    // Weakly not-taken / weakly local starting points.
    localparam int CHOOSE_INIT = (1 << (CHOOSE_W - 1)) - 1;
    localparam int LCTR_INIT   = (1 << (LCTR_W - 1)) - 1;
    localparam int GCTR_INIT   = (1 << (GCTR_W - 1)) - 1;

    logic [CHOOSE_IDX_W-1:0] fetch_cidx, res_cidx;
    logic [LHIST_IDX_W-1:0]  fetch_lidx, res_lidx;
    logic [CHOOSE_W-1:0]     choose_val;
    logic [LCTR_W-1:0]       lctr_val;
    logic [GCTR_W-1:0]       gctr_val;
    logic [LHIST_W-1:0]      lhist_rd;
    logic [GHIST_W-1:0]      ghist;
    tp_train_t               choose_tr, ctr_tr;

    assign fetch_cidx = fetch_pc[PC_LSB +: CHOOSE_IDX_W];
    assign res_cidx   = res_pc[PC_LSB +: CHOOSE_IDX_W];
    assign fetch_lidx = fetch_pc[PC_LSB +: LHIST_IDX_W];
    assign res_lidx   = res_pc[PC_LSB +: LHIST_IDX_W];

    always_comb begin
        choose_tr = tp_chooser_train(res_valid, res_pred_local, res_pred_global, res_taken);
        ctr_tr.en = res_valid;
        ctr_tr.up = res_taken;
    end

    tp_sat_table #(.IDX_W(CHOOSE_IDX_W), .CW(CHOOSE_W), .INIT(CHOOSE_INIT)) u_chooser (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(fetch_cidx), .rd_val(choose_val),
        .upd_en(choose_tr.en), .upd_up(choose_tr.up), .upd_idx(res_cidx)
    );

    tp_hist_table #(.IDX_W(LHIST_IDX_W), .HW(LHIST_W)) u_lhist (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(fetch_lidx), .rd_hist(lhist_rd),
        .wr_en(res_valid), .wr_idx(res_lidx), .wr_bit(res_taken)
    );

    tp_sat_table #(.IDX_W(LHIST_W), .CW(LCTR_W), .INIT(LCTR_INIT)) u_lctr (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(lhist_rd), .rd_val(lctr_val),
        .upd_en(ctr_tr.en), .upd_up(ctr_tr.up), .upd_idx(res_lhist)
    );

    tp_ghr #(.HW(GHIST_W)) u_ghr (
        .clk(clk), .rst_n(rst_n),
        .shift_en(res_valid), .shift_bit(res_taken), .hist(ghist)
    );

    tp_sat_table #(.IDX_W(GHIST_W), .CW(GCTR_W), .INIT(GCTR_INIT)) u_gctr (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(ghist), .rd_val(gctr_val),
        .upd_en(ctr_tr.en), .upd_up(ctr_tr.up), .upd_idx(res_ghist)
    );

    assign pred_local  = lctr_val[LCTR_W-1];
    assign pred_global = gctr_val[GCTR_W-1];
    assign pred_taken  = choose_val[CHOOSE_W-1] ? pred_global : pred_local;
    assign snap_lhist  = lhist_rd;
    assign snap_ghist  = ghist;
endmodule

// File: rtl/tp_checker.sv
module tp_checker #(
    parameter int PC_W    = 32,
    parameter int LHIST_W = 10,
    parameter int GHIST_W = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic [PC_W-1:0]    fetch_pc,
    input logic               pred_taken,
    input logic               pred_local,
    input logic               pred_global,
    input logic [LHIST_W-1:0] snap_lhist,
    input logic [GHIST_W-1:0] snap_ghist,
    input logic               res_valid,
    input logic [PC_W-1:0]    res_pc,
    input logic               res_taken
);
    // R1: first cycle out of reset sees empty global history and local selection.
    assert_reset_ghist_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (snap_ghist == '0 && pred_taken == pred_local));

    // R2: when both sides agree the final prediction cannot differ.
    assert_select_agree_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_local == pred_global) |-> (pred_taken == pred_local));

    // R6: outcome enters the global history at bit 0.
    assert_ghist_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> (snap_ghist == {$past(snap_ghist[GHIST_W-2:0]), $past(res_taken)}));

    // R10: no resolve, no history motion.
    assert_ghist_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |=> $stable(snap_ghist));

    // R3: resolving the looked-up address shifts its local history.
    assert_lhist_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && fetch_pc == res_pc) |=>
            (!$stable(fetch_pc) ||
             snap_lhist == {$past(snap_lhist[LHIST_W-2:0]), $past(res_taken)}));
endmodule

bind tournament_predictor tp_checker #(
    .PC_W(PC_W), .LHIST_W(LHIST_W), .GHIST_W(GHIST_W)
) u_tp_checker (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
    .pred_taken(pred_taken), .pred_local(pred_local), .pred_global(pred_global),
    .snap_lhist(snap_lhist), .snap_ghist(snap_ghist),
    .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken)
);

// File: tb/tournament_predictor_test.sv
module tournament_predictor_test;
    localparam int CLK_PERIOD = 10;
    localparam int PCW = 8;
    localparam int PCL = 2;
    localparam int CIW = 3;
    localparam int LIW = 2;
    localparam int LHW = 3;
    localparam int GHW = 3;
    localparam int LMAX = 7;
    localparam int GMAX = 3;
    localparam int CMAX = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [PCW-1:0] fetch_pc = '0;
    logic pred_taken, pred_local, pred_global;
    logic [LHW-1:0] snap_lhist;
    logic [GHW-1:0] snap_ghist;
    logic res_valid = 1'b0;
    logic [PCW-1:0] res_pc = '0;
    logic res_taken = 1'b0;
    logic [LHW-1:0] res_lhist = '0;
    logic [GHW-1:0] res_ghist = '0;
    logic res_pred_local = 1'b0;
    logic res_pred_global = 1'b0;

    int n_checks = 0;
    int n_fail = 0;
    logic [15:0] lfsr = 16'hACE1;

    // Reference state
    int m_ch [1<<CIW];
    int m_lh [1<<LIW];
    int m_lc [1<<LHW];
    int m_gc [1<<GHW];
    int m_ghr;

    always #(CLK_PERIOD/2) clk = ~clk;

    tournament_predictor #(
        .PC_W(PCW), .PC_LSB(PCL), .CHOOSE_IDX_W(CIW), .CHOOSE_W(2),
        .LHIST_IDX_W(LIW), .LHIST_W(LHW), .LCTR_W(3), .GHIST_W(GHW), .GCTR_W(2)
    ) uut (.*);

    function automatic logic [15:0] rnd();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr;
    endfunction

    function automatic int stepc(int v, int mx, logic up);
        if (up) return (v < mx) ? v + 1 : v;
        return (v > 0) ? v - 1 : v;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int cidx(logic [PCW-1:0] pc); return int'(pc[PCL +: CIW]); endfunction
    function automatic int lidx(logic [PCW-1:0] pc); return int'(pc[PCL +: LIW]); endfunction

    // Lookup at pc and compare every output to the reference.
    task automatic look(logic [PCW-1:0] pc, string tag);
        int elh, epl, epg, ep;
        fetch_pc = pc;
        #1;
        elh = m_lh[lidx(pc)];
        epl = (m_lc[elh] >= 4) ? 1 : 0;
        epg = (m_gc[m_ghr] >= 2) ? 1 : 0;
        ep  = (m_ch[cidx(pc)] >= 2) ? epg : epl;
        chk({tag, "/R3"}, "snap_lhist", int'(snap_lhist), elh);
        chk({tag, "/R6"}, "snap_ghist", int'(snap_ghist), m_ghr);
        chk({tag, "/R4"}, "pred_local", int'(pred_local), epl);
        chk({tag, "/R5"}, "pred_global", int'(pred_global), epg);
        chk({tag, "/R2"}, "pred_taken", int'(pred_taken), ep);
    endtask

    task automatic sweep(string tag);
        for (int i = 0; i < (1 << CIW); i++) look(PCW'(i << PCL), tag);
        look(PCW'(8'hE4), tag); // aliases low index bits
    endtask

    task automatic resolve(logic [PCW-1:0] pc, logic t, int gh, int lh, logic pl, logic pg);
        int li;
        @(negedge clk);
        res_valid = 1'b1; res_pc = pc; res_taken = t;
        res_ghist = GHW'(gh); res_lhist = LHW'(lh);
        res_pred_local = pl; res_pred_global = pg;
        @(posedge clk);
        li = lidx(pc);
        if ((pl == t) != (pg == t)) m_ch[cidx(pc)] = stepc(m_ch[cidx(pc)], CMAX, pg == t); // R7
        m_lc[lh] = stepc(m_lc[lh], LMAX, t);                                                 // R8
        m_gc[gh] = stepc(m_gc[gh], GMAX, t);                                                 // R8
        m_lh[li] = ((m_lh[li] << 1) | int'(t)) & ((1 << LHW) - 1);
        m_ghr    = ((m_ghr << 1) | int'(t)) & ((1 << GHW) - 1);
        #1;
        res_valid = 1'b0;
    endtask

    // Resolve with the snapshot a real front end would have captured.
    task automatic resolve_live(logic [PCW-1:0] pc, logic t);
        int lh;
        lh = m_lh[lidx(pc)];
        resolve(pc, t, m_ghr, lh, m_lc[lh] >= 4, m_gc[m_ghr] >= 2);
    endtask

    initial begin
        logic [15:0] r;
        logic [PCW-1:0] pc;
        for (int i = 0; i < (1 << CIW); i++) m_ch[i] = 1;
        for (int i = 0; i < (1 << LIW); i++) m_lh[i] = 0;
        for (int i = 0; i < (1 << LHW); i++) m_lc[i] = 3;
        for (int i = 0; i < (1 << GHW); i++) m_gc[i] = 1;
        m_ghr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset contents
        sweep("R1");

        // R9: consistent predict-then-resolve traffic
        for (int s = 0; s < 150; s++) begin
            r = rnd();
            pc = {r[5:0], 2'b00};
            resolve_live(pc, r[9] | r[10]);
            look(pc, "R9");
            look(pc ^ PCW'(8'h0C), "R9");
        end
        sweep("R9");

        // R7 R8: arbitrary snapshots and component votes
        for (int s = 0; s < 250; s++) begin
            r = rnd();
            pc = {r[5:0], 2'b00};
            resolve(pc, r[6], int'(r[9:7]), int'(r[12:10]), r[13], r[14]);
            look(pc, "R7");
        end
        sweep("R8");

        // R4 R5 R7: drive one address into both saturation limits
        for (int s = 0; s < 12; s++) begin
            resolve(PCW'(8'h10), 1'b1, 5, 6, 1'b0, 1'b1);
            look(PCW'(8'h10), "R5");
        end
        for (int s = 0; s < 12; s++) begin
            resolve(PCW'(8'h10), 1'b0, 5, 6, 1'b0, 1'b1);
            look(PCW'(8'h10), "R4");
        end
        sweep("R7");

        // R10: garbage on resolve inputs while not valid
        for (int s = 0; s < 6; s++) begin
            @(negedge clk);
            r = rnd();
            res_valid = 1'b0; res_pc = r[7:0]; res_taken = r[8];
            res_ghist = r[11:9]; res_lhist = r[14:12];
            res_pred_local = r[15]; res_pred_global = r[0];
        end
        @(negedge clk);
        sweep("R10");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule